// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms the 32-bit byte address of a memory operand from an addressing-mode code, the contents of up to two general registers, a scale code and a signed displacement. It takes the whole eight-entry general register file as a flat vector and selects the base and index words itself. It then applies a shift of 0 to 3 bits to the index, sign-extends a narrow displacement and adds the terms. It also rejects encodings that the addressing scheme forbids. The address has no alignment requirement, and every sum wraps modulo 2^32.

A decode stage drives one request per cycle with `in_valid` high. The result is captured on that clock edge and appears with `out_valid` one cycle later. Immediate and register operands produce no address. For these the unit raises an operand-kind indication and drives the address to zero. An illegal encoding raises `bad_enc` and also gives a zero address.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and until the first accepted request, `out_valid`, `ea`, `imm_op`, `reg_op` and `bad_enc` are all zero.
- R2: A request accepted with `in_valid` high appears on the outputs with `out_valid` high in the following cycle. In a cycle after `in_valid` was low, `out_valid` is low and `ea` and the flags keep their previous values.
- R3: With `disp_wide` = 1 the displacement is all 32 bits of `disp`. With `disp_wide` = 0 it is `disp[7:0]` sign-extended to 32 bits.
- R4: Scale code s (0..3) multiplies the index register value by 2^s, that is, by 1, 2, 4 or 8.
- R5: Mode codes select the address: 1 gives `disp`; 3 gives base; 4 gives base + displacement; 5 gives index*scale + displacement; 6 gives base + index*scale + displacement. Base and index are the register file words numbered `base_sel` and `index_sel`, where word k sits at bits [32k+31:32k].
- R6: Mode 0 (immediate) gives `imm_op` = 1 and `ea` = 0. Mode 2 (register operand) gives `reg_op` = 1 and `ea` = 0.
- R7: In modes 5 and 6, an `index_sel` of 4 (the stack pointer) sets `bad_enc` = 1 and forces `ea` = 0.
- R8: Mode 5 or mode 1 with `disp_wide` = 0 sets `bad_enc`. Mode code 7 always sets `bad_enc`. In every illegal case `ea` = 0.
- R9: All additions and the scaling wrap modulo 2^32, and no overflow is reported. Base 1000, index 40, scale 4 and displacement 200 give 1360.
- R10: Selectors a mode does not use have no effect. An `index_sel` of 4 in modes 0 to 4 does not set `bad_enc`, and `scale` and `index_sel` do not change the result of modes 1, 3 and 4.
- R11: At most one of `imm_op`, `reg_op` and `bad_enc` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| scale | input | 2 | Scale code: the index is shifted left by this amount |
| disp | input | 32 | Displacement field, or the absolute address in mode 1 |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: 8-bit displacement in disp[7:0] |
| regs_flat | input | 256 | Eight 32-bit general registers, register k in bits [32k+31:32k] |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective byte address |
| imm_op | output | 1 | Operand is immediate |
| reg_op | output | 1 | Operand is a register |
| bad_enc | output | 1 | Illegal encoding |

## Verification
Every mode code is crossed with every scale code, every base and index register number, both displacement widths and three displacement values. The displacement values are chosen so that the low byte is 0x80, 0x7F and 0xC8. A wrong sign extension therefore cannot hide behind a value that looks the same either way. Two register files are used. One holds small distinct words, which tells apart a swapped base or index selection. The other holds words near 2^32, which forces the sums to wrap. Directed cases add the worked example 1360, a hold with inputs changing while `in_valid` is low, and the reset state.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
  localparam int unsigned SCALE_W  = 2;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned SP_CODE  = 4;

  typedef enum logic [2:0] {
    AM_IMM    = 3'd0,
    AM_ABS    = 3'd1,
    AM_REG    = 3'd2,
    AM_IND    = 3'd3,
    AM_BDISP  = 3'd4,
    AM_XDISP  = 3'd5,
    AM_BXDISP = 3'd6,
    AM_RSVD   = 3'd7
  } am_e;

  typedef struct packed {
    logic imm;
    logic regop;
    logic bad;
  } ea_flags_t;
endpackage

// File: rtl/ea_regsel.sv
module ea_regsel #(
  parameter int unsigned W     = 32,
  parameter int unsigned NREG  = 8,
  parameter int unsigned SEL_W = $clog2(NREG)
) (
  input  logic [NREG*W-1:0] regs_flat,
  input  logic [SEL_W-1:0]  sel,
  output logic [W-1:0]      word
);
  logic [W-1:0] regs_a [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs_a[g] = regs_flat[g*W +: W];
  end

  assign word = regs_a[sel];
endmodule

// File: rtl/ea_dispext.sv
module ea_dispext #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 8
) (
  input  logic [W-1:0] disp,
  input  logic         wide,
  output logic [W-1:0] disp_ext
);
  localparam int unsigned PAD_W = W - NW;

  logic [W-1:0] narrow_ext;

  assign narrow_ext = {{PAD_W{disp[NW-1]}}, disp[NW-1:0]};
  assign disp_ext   = wide ? disp : narrow_ext;
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
  parameter int unsigned W       = 32,
  parameter int unsigned SCALE_W = 2
) (
  input  logic [W-1:0]       val,
  input  logic [SCALE_W-1:0] code,
  output logic [W-1:0]       scaled
);
  assign scaled = val << code;
endmodule

// File: rtl/ea_combine.sv
module ea_combine
  import ea_gen_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned SP_SEL  = 4
) (
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] index_sel,
  input  logic             wide,
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     scaled_idx,
  input  logic [W-1:0]     disp_ext,
  output logic [W-1:0]     ea_n,
  output ea_flags_t        flags_n
);
  logic idx_is_sp;

  assign idx_is_sp = (index_sel == SEL_W'(SP_SEL));

  always_comb begin
    ea_n    = '0;
    flags_n = '0;
    unique case (am_e'(mode))
      AM_IMM:    flags_n.imm   = 1'b1;
      AM_REG:    flags_n.regop = 1'b1;
      AM_ABS: begin
        if (!wide) flags_n.bad = 1'b1;
        else       ea_n        = disp_ext;
      end
      AM_IND:    ea_n = base;
      AM_BDISP:  ea_n = base + disp_ext;
      AM_XDISP: begin
        if (idx_is_sp || !wide) flags_n.bad = 1'b1;
        else                    ea_n        = scaled_idx + disp_ext;
      end
      AM_BXDISP: begin
        if (idx_is_sp) flags_n.bad = 1'b1;
        else           ea_n        = base + scaled_idx + disp_ext;
      end
      default:   flags_n.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int unsigned W       = ADDR_W,
  parameter int unsigned NREG    = NUM_REGS,
  parameter int unsigned SCW     = SCALE_W,
  parameter int unsigned NW      = NARROW_W,
  parameter int unsigned SP_SEL  = SP_CODE,
  localparam int unsigned SW     = $clog2(NREG),
  localparam int unsigned RF_W   = NREG * W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      mode,
  input  logic [SW-1:0]   base_sel,
  input  logic [SW-1:0]   index_sel,
  input  logic [SCW-1:0]  scale,
  input  logic [W-1:0]    disp,
  input  logic            disp_wide,
  input  logic [RF_W-1:0] regs_flat,
  output logic            out_valid,
  output logic [W-1:0]    ea,
  output logic            imm_op,
  output logic            reg_op,
  output logic            bad_enc
);
  logic [1:0]  rst_sync;
  logic        rst_q;
  logic [W-1:0] base_w, index_w, scaled_w, disp_w, ea_n;
  ea_flags_t   flags_n;

  logic         vld_d, vld_q;
  logic [W-1:0] ea_d, ea_q;
  ea_flags_t    fl_d, fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  ea_regsel #(.W(W), .NREG(NREG), .SEL_W(SW)) u_base (
    .regs_flat(regs_flat), .sel(base_sel), .word(base_w)
  );

  ea_regsel #(.W(W), .NREG(NREG), .SEL_W(SW)) u_index (
    .regs_flat(regs_flat), .sel(index_sel), .word(index_w)
  );

  ea_scaler #(.W(W), .SCALE_W(SCW)) u_scale (
    .val(index_w), .code(scale), .scaled(scaled_w)
  );

  ea_dispext #(.W(W), .NW(NW)) u_disp (
    .disp(disp), .wide(disp_wide), .disp_ext(disp_w)
  );

  ea_combine #(.W(W), .SEL_W(SW), .SP_SEL(SP_SEL)) u_comb (
    .mode(mode), .index_sel(index_sel), .wide(disp_wide),
    .base(base_w), .scaled_idx(scaled_w), .disp_ext(disp_w),
    .ea_n(ea_n), .flags_n(flags_n)
  );

  always_comb begin
    vld_d = in_valid;
    ea_d  = ea_q;
    fl_d  = fl_q;
    if (in_valid) begin
      ea_d = ea_n;
      fl_d = flags_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      ea_q  <= '0;
      fl_q  <= '0;
    end else begin
      vld_q <= vld_d;
      ea_q  <= ea_d;
      fl_q  <= fl_d;
    end
  end

  assign out_valid = vld_q;
  assign ea        = ea_q;
  assign imm_op    = fl_q.imm;
  assign reg_op    = fl_q.regop;
  assign bad_enc   = fl_q.bad;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 8,
  parameter int unsigned SW   = 3,
  parameter int unsigned SP   = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic            in_valid,
  input logic [2:0]      mode,
  input logic [SW-1:0]   base_sel,
  input logic [SW-1:0]   index_sel,
  input logic [NREG*W-1:0] regs_flat,
  input logic            out_valid,
  input logic [W-1:0]    ea,
  input logic            imm_op,
  input logic            reg_op,
  input logic            bad_enc
);
  logic [W-1:0] base_word;
  assign base_word = regs_flat[base_sel*W +: W];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(ea) && $stable(bad_enc));
  a_r5_indirect_base: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mode == 3'd3) |=> ea == $past(base_word));
  a_r6_no_addr_operand: assert property (@(posedge clk) disable iff (!rst_q)
    (imm_op || reg_op) |-> ea == '0);
  a_r7_sp_index: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (mode == 3'd5 || mode == 3'd6) && index_sel == SW'(SP)) |=> bad_enc);
  a_r8_bad_zero: assert property (@(posedge clk) disable iff (!rst_q)
    bad_enc |-> ea == '0);
  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mode == 3'd7) |=> bad_enc);
  a_r11_kind_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({imm_op, reg_op, bad_enc}));
endmodule

bind ea_gen ea_gen_chk #(.W(W), .NREG(NREG), .SW(SW), .SP(SP_SEL)) u_chk (
  .clk(clk), .rst_q(rst_q), .in_valid(in_valid), .mode(mode),
  .base_sel(base_sel), .index_sel(index_sel), .regs_flat(regs_flat),
  .out_valid(out_valid), .ea(ea), .imm_op(imm_op), .reg_op(reg_op),
  .bad_enc(bad_enc)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   mode;
  logic [2:0]   base_sel, index_sel;
  logic [1:0]   scale;
  logic [31:0]  disp;
  logic         disp_wide;
  logic [255:0] regs_flat;
  logic         out_valid;
  logic [31:0]  ea;
  logic         imm_op, reg_op, bad_enc;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .scale(scale),
    .disp(disp), .disp_wide(disp_wide), .regs_flat(regs_flat),
    .out_valid(out_valid), .ea(ea), .imm_op(imm_op), .reg_op(reg_op),
    .bad_enc(bad_enc)
  );

  function automatic logic [31:0] rword(input logic [255:0] rf, input logic [2:0] k);
    return rf[k*32 +: 32];
  endfunction

  // Reference model built from the requirement text: {ea, imm, reg, bad}
  function automatic logic [34:0] model(input logic [2:0] m, input logic [2:0] bs,
      input logic [2:0] xs, input logic [1:0] s, input logic [31:0] d,
      input logic w, input logic [255:0] rf);
    logic [31:0] dx, bv, xv, e;
    logic i, r, b;
    dx = w ? d : {{24{d[7]}}, d[7:0]};
    bv = rword(rf, bs);
    xv = rword(rf, xs) * (32'd1 << s);
    e = 32'd0; i = 1'b0; r = 1'b0; b = 1'b0;
    case (m)
      3'd0: i = 1'b1;
      3'd1: if (w) e = d; else b = 1'b1;
      3'd2: r = 1'b1;
      3'd3: e = bv;
      3'd4: e = bv + dx;
      3'd5: if (xs == 3'd4 || !w) b = 1'b1; else e = xv + dx;
      3'd6: if (xs == 3'd4) b = 1'b1; else e = bv + xv + dx;
      default: b = 1'b1;
    endcase
    return {e, i, r, b};
  endfunction

  function automatic string req_of(input logic [2:0] m, input logic [2:0] xs,
      input logic w, input logic [1:0] s);
    if (m == 3'd7) return "R8";
    if ((m == 3'd5 || m == 3'd6) && xs == 3'd4) return "R7";
    if ((m == 3'd5 || m == 3'd1) && !w) return "R8";
    if (m == 3'd0 || m == 3'd2) return "R6";
    if (m <= 3'd4 && xs == 3'd4) return "R10";
    if (m == 3'd4 && !w) return "R3";
    if (m >= 3'd5 && s != 2'd0) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [34:0] exp_v, input logic exp_vld);
    n_tests++;
    if (out_valid !== exp_vld || {ea, imm_op, reg_op, bad_enc} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b ea=%h i/r/b=%b%b%b, expected vld=%0b ea=%h i/r/b=%b",
               req, out_valid, ea, imm_op, reg_op, bad_enc, exp_vld, exp_v[34:3], exp_v[2:0]);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [2:0] bs, input logic [2:0] xs,
      input logic [1:0] s, input logic [31:0] d, input logic w);
    in_valid = 1'b1; mode = m; base_sel = bs; index_sel = xs;
    scale = s; disp = d; disp_wide = w;
  endtask

  logic [255:0] rf0, rf1;
  logic [31:0]  dvals [3];

  initial begin
    for (int k = 0; k < 8; k++) begin
      rf0[k*32 +: 32] = 32'h0000_0100 * (k + 1) + 32'h11 * k;
      rf1[k*32 +: 32] = 32'hFFFF_FFF0 - 32'h0123_4567 * k + k;
    end
    dvals[0] = 32'h1234_5680;
    dvals[1] = 32'hFFFF_FF7F;
    dvals[2] = 32'h8000_00C8;

    rst_n = 1'b0; in_valid = 1'b0; mode = '0; base_sel = '0; index_sel = '0;
    scale = '0; disp = '0; disp_wide = 1'b0; regs_flat = rf0;
    repeat (3) @(negedge clk);
    check("R1", 35'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 35'd0, 1'b0);

    // Worked example (R9): 1000 + 40*4 + 200 = 1360
    regs_flat = rf0;
    regs_flat[5*32 +: 32] = 32'd1000;
    regs_flat[6*32 +: 32] = 32'd40;
    drive(3'd6, 3'd5, 3'd6, 2'd2, 32'd200, 1'b1);
    @(negedge clk);
    check("R9", {32'd1360, 3'b000}, 1'b1);

    // Wrap-around (R9)
    regs_flat[5*32 +: 32] = 32'hFFFF_FFFF;
    regs_flat[6*32 +: 32] = 32'h8000_0001;
    drive(3'd6, 3'd5, 3'd6, 2'd3, 32'h0000_0010, 1'b1);
    @(negedge clk);
    check("R9", {32'h0000_0017, 3'b000}, 1'b1);

    // Hold while idle (R2): inputs change, outputs keep value
    in_valid = 1'b0; mode = 3'd7; disp = 32'hDEAD_BEEF; regs_flat = rf1;
    @(negedge clk);
    check("R2", {32'h0000_0017, 3'b000}, 1'b0);
    @(negedge clk);
    check("R2", {32'h0000_0017, 3'b000}, 1'b0);

    // Near-exhaustive sweep: one vector per cycle
    for (int rs = 0; rs < 2; rs++) begin
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 4; s++)
          for (int xs = 0; xs < 8; xs++)
            for (int bs = 0; bs < 8; bs++)
              for (int w = 0; w < 2; w++)
                for (int dv = 0; dv < 3; dv++) begin
                  logic [255:0] rf;
                  logic [34:0]  ev;
                  rf = (rs == 0) ? rf0 : rf1;
                  regs_flat = rf;
                  drive(3'(m), 3'(bs), 3'(xs), 2'(s), dvals[dv], w[0]);
                  ev = model(3'(m), 3'(bs), 3'(xs), 2'(s), dvals[dv], w[0], rf);
                  @(negedge clk);
                  check((rs == 1 && m >= 4 && m <= 6) ? "R9" : req_of(3'(m), 3'(xs), w[0], 2'(s)),
                        ev, 1'b1);
                end
    end

    // Valid drops after a stream (R2)
    in_valid = 1'b0;
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: out_valid=%0b expected 0", out_valid);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule